// File: doc/BRIEF.md
# Gen2 Stuck-Recovery Link Monitor

This block sits beside a PCI Express controller and watches the link-training debug outputs once monitoring is enabled. First it waits for training to finish. It makes a bounded number of attempts spaced by a retry interval. If the link never leaves training, it raises a failure flag and freezes a copy of the debug vector for later inspection.

Once the link is up, the monitor checks its inputs again after every retry interval. The case it looks for is a hung speed change to the second-generation rate. In that case the training state machine is parked in its recovery receiver-lock state while the PHY reports that its receiver is not valid. When this happens, the monitor performs a read-modify-write on a PHY receiver-override register to force two enable bits on. It holds them for a programmable time and then performs a second read-modify-write to release them.

The monitor reaches the PHY register through a simple request/acknowledge port. Every interval is a parameter counted in clock cycles. Because of this, the same block runs with millisecond intervals in silicon and with a few cycles in simulation.

Top module: `gen2_link_monitor`

## Requirements
- R1: After synchronous reset, link_ready, link_fail and recov_count are 0 and reg_req is low.
- R2: While debug bit 36 (bit 4 of the upper 32-bit half of dbg_vec) is 1, the link counts as training: link_ready is 0 and no register request is started.
- R3: After enable, the link-up test runs once immediately and then once per retry interval. The first test that sees bit 36 clear sets link_ready.
- R4: If MAX_TRIES consecutive link-up tests all see training, link_fail is set and both halves of dbg_vec are captured on fail_dbg_lo/fail_dbg_hi. link_fail stays set while enabled, and link_ready and link_fail are never both 1.
- R5: rx_valid_in carries bit 0 of PHY register 0x100D. When it is 1, no recovery is started.
- R6: A stuck link means the low 6 bits of dbg_vec equal 0x0D, rx_valid_in is 0 and bit 36 is 0. In that case the block reads register 0x1005 and writes back the read value with bits 5 and 3 set, keeping all other bits.
- R7: At least HOLD_CYC cycles after the setting write is acknowledged, a second read of 0x1005 is made. It is followed by a write of the read value with bits 5 and 3 cleared and the other bits kept.
- R8: A training state other than 0x0D (compared on the low 6 bits only) never starts a recovery, even when rx_valid_in is 0.
- R9: recov_count increments by one for every acknowledged setting write and saturates at 255.
- R10: After a recovery finishes, at least RETRY_CYC cycles pass before the next evaluation can start another one.
- R11: Deasserting mon_en returns the monitor to idle, clearing link_ready and link_fail. If the override bits are set at that moment, the clearing read-modify-write is still performed.
- R12: reg_req, once raised, stays high with stable reg_addr, reg_we and reg_wdata until reg_ack, and every request addresses register 0x1005.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitor enable; low forces idle |
| dbg_vec | input | 64 | Link-training debug vector (upper half = bits 63:32) |
| rx_valid_in | input | 1 | PHY receiver-valid status bit |
| reg_req | output | 1 | PHY register request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | PHY register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | One-cycle acknowledge of the pending request |
| reg_rdata | input | 16 | Read data, valid with reg_ack on a read |
| link_ready | output | 1 | Link trained and not in training at last check |
| link_fail | output | 1 | Link never came up within the allowed tests |
| fail_dbg_lo | output | 32 | Captured lower debug half at failure |
| fail_dbg_hi | output | 32 | Captured upper debug half at failure |
| recov_count | output | 8 | Saturating count of recovery pulses |

## Verification
The hardest state to reach is a disable that lands while the override bits are held set. The stimulus first drives a stuck pattern and then waits until the PHY register model shows bits 5 and 3 set. Only then does it drop the enable and check that the model returns to its original value. Saturation of the recovery counter is the second hard case: the bench holds the stuck pattern for hundreds of recovery rounds, with short parameter values. Separate gap measurements in the bus model confirm the hold time and the re-evaluation delay.

// File: rtl/lm_pkg.sv
package lm_pkg;

    // Monitor sequencer states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_GAP,
        ST_FAIL,
        ST_MGAP,
        ST_EVAL,
        ST_RDSET,
        ST_WRSET,
        ST_HOLD,
        ST_RDCLR,
        ST_WRCLR
    } mon_state_e;

    // Link view decoded from the debug inputs
    typedef struct packed {
        logic training;
        logic rx_ok;
        logic rcv_lock;
    } link_view_t;

    localparam int TRAIN_BIT    = 4;       // bit within upper debug half
    localparam int LTSSM_W      = 6;
    localparam int RCV_LOCK     = 'h0D;
    localparam int OVR_REG_ADDR = 'h1005;
    localparam int DATA_EN_BIT  = 5;
    localparam int PLL_EN_BIT   = 3;

    function automatic logic is_port_state(mon_state_e s);
        return (s == ST_RDSET) || (s == ST_WRSET) ||
               (s == ST_RDCLR) || (s == ST_WRCLR);
    endfunction

    function automatic logic is_recovery_state(mon_state_e s);
        return is_port_state(s) || (s == ST_HOLD);
    endfunction

    function automatic logic is_write_state(mon_state_e s);
        return (s == ST_WRSET) || (s == ST_WRCLR);
    endfunction

endpackage

// File: rtl/lm_gap_timer.sv
module lm_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0) && !load;

    // R10
    tmr_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/lm_sat_cnt.sv
module lm_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == TOP && !clr) |=> (count == TOP));
endmodule

// File: rtl/lm_snapshot.sv
module lm_snapshot #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (cap) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/gen2_link_monitor.sv
module gen2_link_monitor
    import lm_pkg::*;
#(
    parameter int DBG_W     = 64,
    parameter int REG_W     = 16,
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 8,
    parameter int RETRY_CYC = 25000,
    parameter int HOLD_CYC  = 625000,
    parameter int MAX_TRIES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_en,
    input  logic [DBG_W-1:0]  dbg_vec,
    input  logic              rx_valid_in,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_ack,
    input  logic [REG_W-1:0]  reg_rdata,
    output logic              link_ready,
    output logic              link_fail,
    output logic [DBG_W/2-1:0] fail_dbg_lo,
    output logic [DBG_W/2-1:0] fail_dbg_hi,
    output logic [CNT_W-1:0]  recov_count
);
    localparam int WORD_W  = DBG_W / 2;
    localparam int TMR_MAX = (HOLD_CYC > RETRY_CYC) ? HOLD_CYC : RETRY_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int TRY_W   = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0]   LAST_TRY  = TRY_W'(MAX_TRIES - 1);
    localparam logic [TMR_W-1:0]   RETRY_VAL = TMR_W'(RETRY_CYC);
    localparam logic [TMR_W-1:0]   HOLD_VAL  = TMR_W'(HOLD_CYC);
    localparam logic [REG_W-1:0]   OVR_MASK  = (REG_W'(1) << DATA_EN_BIT) |
                                               (REG_W'(1) << PLL_EN_BIT);
    localparam logic [LTSSM_W-1:0] LOCK_CODE = LTSSM_W'(RCV_LOCK);

    mon_state_e       state_q, state_d;
    link_view_t       view;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic             try_inc, try_clr, rec_inc, snap;
    logic [TRY_W-1:0] try_cnt;
    logic [REG_W-1:0] shadow_q;
    logic             ready_q, fail_q;
    logic [DBG_W-1:0] snap_q;

    // Decode of the monitored inputs
    always_comb begin
        view.training = dbg_vec[WORD_W + TRAIN_BIT];
        view.rx_ok    = rx_valid_in;
        view.rcv_lock = (dbg_vec[LTSSM_W-1:0] == LOCK_CODE);
    end

    // Sequencer
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = RETRY_VAL;
        try_inc  = 1'b0;
        rec_inc  = 1'b0;
        snap     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mon_en) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (!view.training) begin
                    state_d  = ST_MGAP;
                    tmr_load = 1'b1;
                end else if (try_cnt == LAST_TRY) begin
                    state_d = ST_FAIL;
                    snap    = 1'b1;
                end else begin
                    try_inc  = 1'b1;
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_exp) state_d = ST_CHECK;
            end
            ST_FAIL: begin
                state_d = ST_FAIL;
            end
            ST_MGAP: begin
                if (tmr_exp) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (!view.training && !view.rx_ok && view.rcv_lock) begin
                    state_d = ST_RDSET;
                end else begin
                    state_d  = ST_MGAP;
                    tmr_load = 1'b1;
                end
            end
            ST_RDSET: begin
                if (reg_ack) state_d = mon_en ? ST_WRSET : ST_IDLE;
            end
            ST_WRSET: begin
                if (reg_ack) begin
                    rec_inc  = 1'b1;
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_VAL;
                end
            end
            ST_HOLD: begin
                if (!mon_en || tmr_exp) state_d = ST_RDCLR;
            end
            ST_RDCLR: begin
                if (reg_ack) state_d = ST_WRCLR;
            end
            ST_WRCLR: begin
                if (reg_ack) begin
                    if (mon_en) begin
                        state_d  = ST_MGAP;
                        tmr_load = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!mon_en && !is_recovery_state(state_q)) begin
            state_d  = ST_IDLE;
            tmr_load = 1'b0;
            try_inc  = 1'b0;
            snap     = 1'b0;
        end
    end

    assign try_clr = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            shadow_q <= '0;
            ready_q  <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (reg_ack && state_q == ST_RDSET) shadow_q <= reg_rdata | OVR_MASK;
            if (reg_ack && state_q == ST_RDCLR) shadow_q <= reg_rdata & ~OVR_MASK;
            if (state_d == ST_IDLE) begin
                ready_q <= 1'b0;
                fail_q  <= 1'b0;
            end else if (snap) begin
                fail_q <= 1'b1;
            end else if (state_q == ST_CHECK || state_q == ST_EVAL) begin
                ready_q <= !view.training;
            end
        end
    end

    lm_gap_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    lm_sat_cnt #(.W(TRY_W)) u_tries (
        .clk   (clk),
        .rst   (rst),
        .clr   (try_clr),
        .inc   (try_inc),
        .count (try_cnt)
    );

    lm_sat_cnt #(.W(CNT_W)) u_recov (
        .clk   (clk),
        .rst   (rst),
        .clr   (1'b0),
        .inc   (rec_inc),
        .count (recov_count)
    );

    lm_snapshot #(.W(DBG_W)) u_snap (
        .clk  (clk),
        .rst  (rst),
        .cap  (snap),
        .din  (dbg_vec),
        .dout (snap_q)
    );

    assign fail_dbg_lo = snap_q[WORD_W-1:0];
    assign fail_dbg_hi = snap_q[DBG_W-1:WORD_W];
    assign reg_req     = is_port_state(state_q);
    assign reg_we      = is_write_state(state_q);
    assign reg_addr    = ADDR_W'(OVR_REG_ADDR);
    assign reg_wdata   = shadow_q;
    assign link_ready  = ready_q;
    assign link_fail   = fail_q;

    // R4
    ready_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(link_ready && link_fail));

    // R4
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (link_fail && mon_en) |=> link_fail);

    // R12
    port_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) &&
                                   $stable(reg_we) && $stable(reg_wdata)));

    // R2
    train_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL && view.training) |=> !reg_req);

    // R9
    recov_mono_chk: assert property (@(posedge clk) disable iff (rst)
        rec_inc |=> (recov_count >= $past(recov_count)));
endmodule

// File: tb/gen2_link_monitor_tb.sv
module gen2_link_monitor_tb;
    localparam int RETRY = 8;
    localparam int HOLD  = 16;
    localparam int TRIES = 10;
    localparam int LAT   = 2;
    localparam int WD_LIMIT = 150000;
    localparam logic [15:0] BASE  = 16'h8142;
    localparam logic [15:0] SETV  = 16'h816A;
    localparam logic [15:0] OADDR = 16'h1005;

    // {lo, hi, rx_valid, expect_recovery, expect_ready}
    localparam logic [66:0] VEC [8] = '{
        {32'h0000000D, 32'h00000000, 1'b0, 1'b1, 1'b1},
        {32'h0000000D, 32'h00000000, 1'b1, 1'b0, 1'b1},
        {32'h0000000C, 32'h00000000, 1'b0, 1'b0, 1'b1},
        {32'h0000000D, 32'h00000010, 1'b0, 1'b0, 1'b0},
        {32'hFFFFFFCD, 32'hFFFFFFEF, 1'b0, 1'b1, 1'b1},
        {32'h0000002D, 32'h00000000, 1'b0, 1'b0, 1'b1},
        {32'h00000011, 32'h00000000, 1'b0, 1'b0, 1'b1},
        {32'h0000004D, 32'h00000000, 1'b0, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mon_en = 1'b0;
    logic [63:0] dbg_vec = '0;
    logic        rx_valid_in = 1'b1;
    logic        reg_req, reg_we, reg_ack;
    logic [15:0] reg_addr, reg_wdata, reg_rdata;
    logic        link_ready, link_fail;
    logic [31:0] fail_dbg_lo, fail_dbg_hi;
    logic [7:0]  recov_count;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0] mem = BASE;
    int lat = 0, nwr_set = 0, nwr_clr = 0, n_req_rise = 0, viol = 0;
    int t_set = 0, t_clr = 0, hold_min = 1 << 30, hold_max = 0, retry_min = 1 << 30;
    logic last_was_clr = 1'b0, prev_req = 1'b0, prev_we = 1'b0;
    logic [15:0] prev_wd = '0, last_set_val = '0, last_clr_val = '0;

    always #2 clk = ~clk;

    gen2_link_monitor #(
        .RETRY_CYC (RETRY),
        .HOLD_CYC  (HOLD),
        .MAX_TRIES (TRIES)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .mon_en      (mon_en),
        .dbg_vec     (dbg_vec),
        .rx_valid_in (rx_valid_in),
        .reg_req     (reg_req),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_ack     (reg_ack),
        .reg_rdata   (reg_rdata),
        .link_ready  (link_ready),
        .link_fail   (link_fail),
        .fail_dbg_lo (fail_dbg_lo),
        .fail_dbg_hi (fail_dbg_hi),
        .recov_count (recov_count)
    );

    initial begin
        reg_ack   = 1'b0;
        reg_rdata = '0;
    end

    // PHY register model and port observer
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (reg_req && !prev_req) begin
            n_req_rise = n_req_rise + 1;
            if (!reg_we && last_was_clr && (cyc - t_clr) < retry_min) retry_min = cyc - t_clr;
        end
        if (reg_req && prev_req && !reg_ack &&
            (reg_we != prev_we || reg_wdata != prev_wd)) viol = viol + 1;
        if (reg_req && reg_addr != OADDR) viol = viol + 1;
        prev_req = reg_req && !reg_ack;
        prev_we  = reg_we;
        prev_wd  = reg_wdata;
        if (reg_ack) begin
            reg_ack = 1'b0;
            prev_req = 1'b0;
        end else if (reg_req) begin
            if (lat == LAT) begin
                lat = 0;
                reg_ack = 1'b1;
                if (reg_we) begin
                    mem = reg_wdata;
                    if ((reg_wdata & 16'h0028) == 16'h0028) begin
                        nwr_set = nwr_set + 1;
                        last_set_val = reg_wdata;
                        t_set = cyc;
                        last_was_clr = 1'b0;
                    end else begin
                        nwr_clr = nwr_clr + 1;
                        last_clr_val = reg_wdata;
                        if (cyc - t_set < hold_min) hold_min = cyc - t_set;
                        if (cyc - t_set > hold_max) hold_max = cyc - t_set;
                        t_clr = cyc;
                        last_was_clr = 1'b1;
                    end
                end else begin
                    reg_rdata = mem;
                end
            end else begin
                lat = lat + 1;
            end
        end
        if (cyc == WD_LIMIT) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog (all reqs) actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_in(input logic [31:0] lo, input logic [31:0] hi, input logic rxv);
        dbg_vec     = {hi, lo};
        rx_valid_in = rxv;
    endtask

    function automatic int sat8(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    initial begin
        int w0, r0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R1 reset state
        chk(link_ready == 1'b0, "R1", "link_ready", link_ready, 0);
        chk(link_fail == 1'b0, "R1", "link_fail", link_fail, 0);
        chk(recov_count == 8'd0, "R1", "recov_count", recov_count, 0);
        chk(reg_req == 1'b0, "R1", "reg_req", reg_req, 0);

        // R2 / R3: training, then link comes up within retries
        set_in(32'h0000000D, 32'h00000010, 1'b0);
        mon_en = 1'b1;
        wait_cyc(40);
        chk(link_ready == 1'b0, "R2", "ready while training", link_ready, 0);
        chk(n_req_rise == 0, "R2", "requests while training", n_req_rise, 0);
        set_in(32'h00000011, 32'h00000000, 1'b1);
        wait_cyc(RETRY + 5);
        chk(link_ready == 1'b1, "R3", "ready after training ends", link_ready, 1);
        chk(link_fail == 1'b0, "R3", "no fail", link_fail, 0);

        // Table walk: R5 R6 R7 R8 R2
        for (int i = 0; i < 8; i++) begin
            logic [66:0] v;
            v = VEC[i];
            w0 = nwr_set;
            set_in(v[66:35], v[34:3], v[2]);
            wait_cyc(2 * (RETRY + HOLD) + 60);
            chk(link_ready == v[0], "R2", $sformatf("vec%0d ready", i), link_ready, v[0]);
            set_in(32'h00000011, 32'h00000000, 1'b1);
            wait_cyc(RETRY + HOLD + 60);
            chk((nwr_set > w0) == v[1], v[1] ? "R6" : "R8",
                $sformatf("vec%0d recovery", i), nwr_set - w0, v[1]);
            chk(mem == BASE, "R7", $sformatf("vec%0d override released", i), mem, BASE);
        end
        chk(last_set_val == SETV, "R6", "set write value", last_set_val, SETV);
        chk(last_clr_val == BASE, "R7", "clear write value", last_clr_val, BASE);
        chk(hold_min >= HOLD && hold_max <= HOLD + 20, "R7", "hold gap",
            hold_min, HOLD);
        chk(retry_min >= RETRY, "R10", "re-evaluation gap", retry_min, RETRY);
        chk(recov_count == 8'(sat8(nwr_set)), "R9", "count tracks pulses",
            recov_count, sat8(nwr_set));

        // R9 single increment
        r0 = recov_count;
        set_in(32'h0000000D, 32'h00000000, 1'b0);
        w0 = nwr_set;
        for (int i = 0; i < 500 && nwr_set == w0; i++) @(negedge clk);
        set_in(32'h00000011, 32'h00000000, 1'b1);
        wait_cyc(RETRY + HOLD + 40);
        chk(recov_count == 8'(r0 + 1), "R9", "increment by one", recov_count, r0 + 1);

        // R11 disable while override bits held
        set_in(32'h0000000D, 32'h00000000, 1'b0);
        for (int i = 0; i < 500 && mem != SETV; i++) @(negedge clk);
        chk(mem == SETV, "R6", "bits set before disable", mem, SETV);
        mon_en = 1'b0;
        wait_cyc(20);
        chk(mem == BASE, "R11", "bits cleared after disable", mem, BASE);
        chk(link_ready == 1'b0, "R11", "ready cleared", link_ready, 0);
        w0 = n_req_rise;
        wait_cyc(40);
        chk(n_req_rise == w0, "R11", "idle issues nothing", n_req_rise - w0, 0);

        // R4 link never comes up
        set_in(32'h12345678, 32'hA0B0C0D0, 1'b1);
        mon_en = 1'b1;
        wait_cyc(70);
        chk(link_fail == 1'b0, "R4", "no fail before last try", link_fail, 0);
        wait_cyc(60);
        chk(link_fail == 1'b1, "R4", "fail after tries", link_fail, 1);
        chk(link_ready == 1'b0, "R4", "ready low on fail", link_ready, 0);
        chk(fail_dbg_lo == 32'h12345678, "R4", "captured lo", fail_dbg_lo, 32'h12345678);
        chk(fail_dbg_hi == 32'hA0B0C0D0, "R4", "captured hi", fail_dbg_hi, 32'hA0B0C0D0);
        set_in(32'h00000011, 32'h00000000, 1'b1);
        wait_cyc(30);
        chk(link_fail == 1'b1, "R4", "fail sticky", link_fail, 1);
        mon_en = 1'b0;
        wait_cyc(3);
        chk(link_fail == 1'b0, "R11", "fail cleared by disable", link_fail, 0);

        // R9 saturation
        mon_en = 1'b1;
        wait_cyc(RETRY + 5);
        chk(link_ready == 1'b1, "R3", "ready immediately", link_ready, 1);
        set_in(32'h0000000D, 32'h00000000, 1'b0);
        for (int i = 0; i < 40000 && recov_count != 8'hFF; i++) @(negedge clk);
        wait_cyc(300);
        chk(recov_count == 8'hFF, "R9", "saturated", recov_count, 255);
        chk(nwr_set > 255, "R9", "pulses beyond saturation", nwr_set, 256);
        mon_en = 1'b0;
        wait_cyc(30);
        chk(mem == BASE, "R11", "released at end", mem, BASE);
        chk(viol == 0, "R12", "port protocol violations", viol, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule